// File: doc/BRIEF.md
# Serial Peripheral Master with Word-Register Access

This block is a serial peripheral interface master that a processor drives through six 32-bit word registers on a simple request/write/address bus. Software writes a word into a single transmit holding register. A shift engine moves that word into its own shift register and sends it most significant bit first in clock mode 0. The serial clock idles low, data is sampled on the rising edge and changed on the falling edge. The engine takes in the same number of bits from the slave at the same time. When the word is complete it is copied into a receive holding register.

Flags show whether each holding register can be used and whether a word was lost. A late transmit write is dropped and flagged. A received word always overwrites the previous one, and an unread previous word is flagged. Per-flag enables combine the flags into one interrupt line. A mask register picks which active-low select lines go low. They go low while a word is on the wire, or continuously when the software-held select bit is set. The data width, the number of select lines and the serial clock divider are parameters.

Top module: `spi_master_mmio`

## Requirements
- R1: After reset, status (word 2) reads 0x060 (TRDY bit 6 = 1, TMT bit 5 = 1, all else 0), control (word 3) reads 0, the select mask (word 5) reads 1, every ss_n line is high, irq is 0 and sclk is low.
- R2: A write to word 1 clears TRDY (bit 6) until the engine takes the word. The word is then sent MSB first on mosi with exactly DATA_W rising sclk edges, one every DIV system clocks, and sclk idles low.
- R3: A write to word 1 while TRDY is 0 sets TOE (bit 4) and is discarded: the held word is unchanged and the word already held is the one transmitted.
- R4: A completed transfer copies the received word into word 0 and sets RRDY (bit 7). A read of word 0 clears RRDY. A write to word 0 changes neither word 0 nor any status bit.
- R5: If RRDY is still 1 when a new word completes, the new word overwrites word 0 and ROE (bit 3) is set.
- R6: E (bit 8) reads as TOE OR ROE. Any write to word 2 clears TOE, ROE and E whatever the data written, and leaves RRDY and TRDY alone.
- R7: TMT (bit 5) is 1 only when the holding register and the shift engine are both empty.
- R8: irq is 1 exactly when an enabled pair is both set. The control enable bits are IROE bit 3, ITOE bit 4, ITRDY bit 6, IRRDY bit 7 and IE bit 8, paired with ROE, TOE, TRDY, RRDY and E.
- R9: ss_n equals the inverted mask while a word is being shifted, or at all times while SSO (control bit 10) is 1. Otherwise all ss_n lines are high.
- R10: Bits without a defined meaning read as 0. Words 1, 4, 6 and 7 read 0, and word 0 above DATA_W reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus access strobe, one cycle per access |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 1 | Combined interrupt request |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the slaves |
| ss_n | output | SLAVES (4) | Active-low slave select lines |

## Verification
The bound checker watches these on every cycle: the transmit overrun flag and the unchanged holding register after a late write, the transmit-empty to transmit-ready relation, the ready and overrun flags set by a completed word, the clearing by a status write, and sclk staying low and rising only during a shift. The bit order on mosi, the word sampled from miso, the sclk period, the select-line levels, the register read values and each interrupt enable pairing are shown only by the bench's scenarios. There, a bench slave model shifts known words back and records what the master sends.

// File: rtl/spi_master_pkg.sv
`timescale 1ns/1ps
package spi_master_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RXD  = 3'd0,
        ADR_TXD  = 3'd1,
        ADR_STAT = 3'd2,
        ADR_CTRL = 3'd3,
        ADR_RSVD = 3'd4,
        ADR_SSEL = 3'd5
    } reg_addr_e;

    // status bit positions
    localparam int ST_ROE  = 3;
    localparam int ST_TOE  = 4;
    localparam int ST_TMT  = 5;
    localparam int ST_TRDY = 6;
    localparam int ST_RRDY = 7;
    localparam int ST_E    = 8;
    // control bit positions
    localparam int CT_IROE  = 3;
    localparam int CT_ITOE  = 4;
    localparam int CT_ITRDY = 6;
    localparam int CT_IRRDY = 7;
    localparam int CT_IE    = 8;
    localparam int CT_SSO   = 10;

    typedef struct packed {
        logic rrdy;
        logic trdy;
        logic tmt;
        logic toe;
        logic roe;
    } stat_t;

    typedef struct packed {
        logic sso;
        logic ie;
        logic irrdy;
        logic itrdy;
        logic itoe;
        logic iroe;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] stat_word(stat_t s);
        logic [BUS_W-1:0] w;
        w = '0;
        w[ST_ROE]  = s.roe;
        w[ST_TOE]  = s.toe;
        w[ST_TMT]  = s.tmt;
        w[ST_TRDY] = s.trdy;
        w[ST_RRDY] = s.rrdy;
        w[ST_E]    = s.toe | s.roe;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_word(ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CT_IROE]  = c.iroe;
        w[CT_ITOE]  = c.itoe;
        w[CT_ITRDY] = c.itrdy;
        w[CT_IRRDY] = c.irrdy;
        w[CT_IE]    = c.ie;
        w[CT_SSO]   = c.sso;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [BUS_W-1:0] w);
        ctrl_t c;
        c.iroe  = w[CT_IROE];
        c.itoe  = w[CT_ITOE];
        c.itrdy = w[CT_ITRDY];
        c.irrdy = w[CT_IRRDY];
        c.ie    = w[CT_IE];
        c.sso   = w[CT_SSO];
        return c;
    endfunction

    function automatic logic irq_of(stat_t s, ctrl_t c);
        return (c.iroe & s.roe) | (c.itoe & s.toe) | (c.itrdy & s.trdy)
             | (c.irrdy & s.rrdy) | (c.ie & (s.toe | s.roe));
    endfunction

endpackage

// File: rtl/spi_master_shift.sv
`timescale 1ns/1ps
module spi_master_shift #(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] start_word,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int HALF  = (DIV < 2) ? 1 : DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= start_word;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_cnt == HALF_LAST) begin
                div_cnt <= '0;
                if (!sclk) begin
                    // rising edge: capture the slave's bit
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[DATA_W-2:0], miso};
                end else begin
                    // falling edge: present the next bit
                    sclk  <= 1'b0;
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    if (bit_cnt == BIT_LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign mosi    = tx_sh[DATA_W-1];
    assign rx_word = rx_sh;

endmodule

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLAVES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              load,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_word,
    output stat_t             stat,
    output ctrl_t             ctrl,
    output logic [SLAVES-1:0] mask,
    output logic              irq
);
    logic              tx_full;
    logic              toe_q;
    logic              roe_q;
    logic              rrdy_q;
    logic [DATA_W-1:0] rx_hold;

    logic wr_tx, wr_stat, wr_ctrl, wr_ssel, rd_rx;
    assign wr_tx   = req && wr && (addr == ADR_TXD);
    assign wr_stat = req && wr && (addr == ADR_STAT);
    assign wr_ctrl = req && wr && (addr == ADR_CTRL);
    assign wr_ssel = req && wr && (addr == ADR_SSEL);
    assign rd_rx   = req && !wr && (addr == ADR_RXD);

    // transmit holding register: a write while full is dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full <= 1'b0;
            tx_word <= '0;
        end else if (wr_tx && !tx_full) begin
            tx_word <= wdata[DATA_W-1:0];
            tx_full <= 1'b1;
        end else if (load) begin
            tx_full <= 1'b0;
        end
    end

    // error flags: a new error in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            toe_q <= 1'b0;
            roe_q <= 1'b0;
        end else begin
            if (wr_tx && tx_full)        toe_q <= 1'b1;
            else if (wr_stat)            toe_q <= 1'b0;
            if (done && rrdy_q && !rd_rx) roe_q <= 1'b1;
            else if (wr_stat)            roe_q <= 1'b0;
        end
    end

    // receive holding register: always overwritten
    always_ff @(posedge clk) begin
        if (rst) begin
            rrdy_q  <= 1'b0;
            rx_hold <= '0;
        end else if (done) begin
            rrdy_q  <= 1'b1;
            rx_hold <= rx_word;
        end else if (rd_rx) begin
            rrdy_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= SLAVES'(1);
        end else begin
            if (wr_ctrl) ctrl <= ctrl_from_word(wdata);
            if (wr_ssel) mask <= wdata[SLAVES-1:0];
        end
    end

    always_comb begin
        stat.rrdy = rrdy_q;
        stat.trdy = !tx_full;
        stat.tmt  = !tx_full && !busy;
        stat.toe  = toe_q;
        stat.roe  = roe_q;
    end

    always_comb begin
        case (addr)
            ADR_RXD:  rdata = BUS_W'(rx_hold);
            ADR_STAT: rdata = stat_word(stat);
            ADR_CTRL: rdata = ctrl_word(ctrl);
            ADR_SSEL: rdata = BUS_W'(mask);
            default:  rdata = '0;
        endcase
    end

    assign tx_valid = tx_full;
    assign irq      = irq_of(stat, ctrl);

endmodule

// File: rtl/spi_master_ssel.sv
`timescale 1ns/1ps
module spi_master_ssel #(
    parameter int SLAVES = 4
) (
    input  logic              active,
    input  logic [SLAVES-1:0] mask,
    output logic [SLAVES-1:0] ss_n
);
    for (genvar i = 0; i < SLAVES; i++) begin : g_line
        assign ss_n[i] = !(active && mask[i]);
    end
endmodule

// File: rtl/spi_master_mmio.sv
`timescale 1ns/1ps
module spi_master_mmio
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLAVES = 4,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SLAVES-1:0] ss_n
);
    logic              busy;
    logic              done;
    logic              load;
    logic              tx_valid;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    stat_t             st;
    ctrl_t             ct;
    logic [SLAVES-1:0] mask;

    assign load = tx_valid && !busy;

    spi_master_regs #(.DATA_W(DATA_W), .SLAVES(SLAVES)) u_regs (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .load(load), .busy(busy),
        .done(done), .rx_word(rx_word), .tx_valid(tx_valid),
        .tx_word(tx_word), .stat(st), .ctrl(ct), .mask(mask), .irq(irq)
    );

    spi_master_shift #(.DATA_W(DATA_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst(rst), .start(load), .start_word(tx_word),
        .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
        .done(done), .rx_word(rx_word)
    );

    spi_master_ssel #(.SLAVES(SLAVES)) u_ssel (
        .active(busy || ct.sso), .mask(mask), .ss_n(ss_n)
    );

endmodule

// File: rtl/spi_master_checker.sv
`timescale 1ns/1ps
module spi_master_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              wr,
    input logic [2:0]        addr,
    input logic              trdy,
    input logic              tmt,
    input logic              toe,
    input logic              roe,
    input logic              rrdy,
    input logic              busy,
    input logic              sclk,
    input logic              done,
    input logic [DATA_W-1:0] tx_word
);
    logic late_tx, stat_wr, rx_rd;
    assign late_tx = req && wr && (addr == 3'd1) && !trdy;
    assign stat_wr = req && wr && (addr == 3'd2);
    assign rx_rd   = req && !wr && (addr == 3'd0);

    assert_late_write_flag_R3: assert property (@(posedge clk) disable iff (rst)
        late_tx |=> toe);
    assert_late_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        late_tx |=> $stable(tx_word));
    assert_empty_means_ready_R7: assert property (@(posedge clk) disable iff (rst)
        tmt |-> trdy);
    assert_word_sets_ready_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> rrdy);
    assert_unread_sets_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        (done && rrdy && !rx_rd) |=> roe);
    assert_status_clears_toe_R6: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> !toe);
    assert_status_clears_roe_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !done) |=> !roe);
    assert_sclk_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);
    assert_sclk_rise_in_shift_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> busy);
endmodule

bind spi_master_mmio spi_master_checker #(.DATA_W(DATA_W)) i_checker (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr),
    .trdy(st.trdy), .tmt(st.tmt), .toe(st.toe), .roe(st.roe),
    .rrdy(st.rrdy), .busy(busy), .sclk(sclk), .done(done),
    .tx_word(tx_word)
);

// File: tb/test_spi_master_mmio.sv
`timescale 1ns/1ps
module test_spi_master_mmio;
    localparam int DATA_W = 8;
    localparam int SLAVES = 4;
    localparam int DIV    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr  = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sclk, mosi, miso;
    logic [SLAVES-1:0] ss_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_master_mmio #(.DATA_W(DATA_W), .SLAVES(SLAVES), .DIV(DIV)) i_spi_master_mmio (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // slave model: mode 0, MSB first
    logic [31:0]       slv = '0;
    logic [15:0]       mcap = '0;
    logic [SLAVES-1:0] sscap = '1;
    int                rises = 0;
    time               t_prev = 0;
    time               period = 0;

    assign miso = slv[31];
    always @(negedge sclk) slv <= slv << 1;
    always @(posedge sclk) begin
        mcap  <= {mcap[14:0], mosi};
        sscap <= ss_n;
        if (rises > 0) period = $time - t_prev;
        t_prev = $time;
        rises  = rises + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 req = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        #2 d = rdata;
        @(posedge clk);
        #1 req = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            peek(3'd2, s);
            if (s[5]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(3'd2, d); check("R1 status after reset", d, 32'h060);
        peek(3'd3, d); check("R1 control after reset", d, 32'h0);
        peek(3'd5, d); check("R1 mask after reset", d, 32'h1);
        check("R1 ss_n after reset", 32'(ss_n), 32'hF);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 sclk after reset", 32'(sclk), 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        bus_write(3'd5, 32'h2);
        slv = {8'h3C, 24'h0};
        rises = 0; mcap = '0;
        bus_write(3'd1, 32'hA5);
        peek(3'd2, d); check("R2 R7 TRDY and TMT low after tx write", d, 32'h0);
        wait_idle();
        check("R2 mosi word MSB first", 32'(mcap[7:0]), 32'hA5);
        check("R2 rising edge count", 32'(rises), 32'(DATA_W));
        check("R2 sclk period", 32'(period), 32'(DIV * 20));
        check("R9 ss_n during transfer", 32'(sscap), 32'hD);
        check("R9 ss_n after transfer", 32'(ss_n), 32'hF);
        peek(3'd2, d); check("R4 RRDY set after word", d, 32'h0E0);
        bus_read(3'd0, d); check("R4 received word", d, 32'h3C);
        peek(3'd2, d); check("R4 read clears RRDY", d, 32'h060);
    endtask

    task automatic t_rx_write();
        logic [31:0] d;
        bus_write(3'd0, 32'h99);
        peek(3'd0, d); check("R4 rx write ignored (data)", d, 32'h3C);
        peek(3'd2, d); check("R4 rx write ignored (status)", d, 32'h060);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        slv = {8'h5A, 8'hC3, 16'h0};
        rises = 0; mcap = '0;
        bus_write(3'd1, 32'h11);
        @(posedge clk);
        bus_write(3'd1, 32'h22);
        bus_write(3'd1, 32'h33);
        peek(3'd2, d); check("R3 R6 TOE and E after late write", d, 32'h110);
        wait_idle();
        wait_idle();
        check("R3 late word discarded", 32'(mcap), 32'h1122);
        peek(3'd2, d); check("R5 ROE with unread word", d, 32'h1F8);
        peek(3'd0, d); check("R5 new word overwrites", d, 32'hC3);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        check("R8 irq with no enables", 32'(irq), 32'h0);
        bus_write(3'd3, 32'h100);
        check("R8 IE with E", 32'(irq), 32'h1);
        bus_write(3'd2, 32'hFFFF_FFFF);
        peek(3'd2, d); check("R6 status write clears errors", d, 32'h0E0);
        check("R8 IE without E", 32'(irq), 32'h0);
        bus_write(3'd3, 32'h080);
        check("R8 IRRDY with RRDY", 32'(irq), 32'h1);
        bus_write(3'd3, 32'h040);
        check("R8 ITRDY with TRDY", 32'(irq), 32'h1);
        bus_write(3'd3, 32'h018);
        check("R8 IROE ITOE without errors", 32'(irq), 32'h0);
        bus_write(3'd3, 32'h0);
    endtask

    task automatic t_sso();
        bus_write(3'd5, 32'h9);
        bus_write(3'd3, 32'h400);
        check("R9 SSO holds selects low", 32'(ss_n), 32'h6);
        bus_write(3'd3, 32'h0);
        check("R9 SSO cleared releases selects", 32'(ss_n), 32'hF);
    endtask

    task automatic t_map();
        logic [31:0] d;
        peek(3'd1, d); check("R10 tx word reads zero", d, 32'h0);
        peek(3'd4, d); check("R10 reserved word reads zero", d, 32'h0);
        peek(3'd6, d); check("R10 word 6 reads zero", d, 32'h0);
        peek(3'd7, d); check("R10 word 7 reads zero", d, 32'h0);
        peek(3'd0, d); check("R10 rx upper bits zero", d, 32'hC3);
        peek(3'd5, d); check("R10 mask upper bits zero", d, 32'h9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_rx_write();
        t_overrun();
        t_irq();
        t_sso();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule